// File: doc/BRIEF.md
# Copyback cache line state controller

This block runs the state of a single data cache line that holds four 32-bit words. The line is always in one of three states: invalid, valid (clean) or modified (dirty). The processor side sends reads, writes and maintenance commands. Each access carries a hit flag, which comes from tag logic outside the block, and a per-access mode bit that selects copyback or write-through. The block decides what memory traffic the access needs, updates the line's data and state, and acknowledges the processor with a one-cycle response pulse. A read response also carries the requested word.

When a miss replaces a dirty line, the old contents are copied into a line-wide push buffer. The new line is then fetched first. The processor is answered as soon as the fill lands, and the buffered victim is written back afterwards. Maintenance commands can do three things: discard the line, push it to memory and drop it, or push it to memory and keep it clean.

The memory side has three valid/ready channels:
- A command channel that names a four-beat fill, a four-beat write-back, or a single-word write.
- An inbound fill-data channel.
- An outbound write-data channel.

The memory may stall any channel at any cycle. The block holds each offered command or data beat steady until it is taken. It never offers fill readiness and a command in the same cycle, and it finishes a fill before it starts the write-back that follows.

Top module: `clc_line_ctrl`

## Requirements
- R1: While reset is held, and on the first idle cycle after it, the line is invalid (line_state 0), req_ready is 1, and mc_valid, wd_valid and rsp_valid are all 0. The line_state encoding is 0 invalid, 1 valid, 2 modified.
- R2: A read (req_op 0) that hits a valid or modified line raises rsp_valid on the following cycle. rsp_rdata holds the addressed word. The state does not change and there is no memory traffic.
- R3: A copyback write (req_op 1, req_wt 0) that hits updates only the addressed cache word and leaves the line modified. It causes no memory traffic and responds on the following cycle.
- R4: A write-through write that hits issues one single-word write: mc_kind 2, mc_word set to the word index, then one wd beat. After that beat it updates the cache word, leaves the line valid, and responds.
- R5: A write-through write that misses issues the same single-word write. It changes neither the cached data nor the line state.
- R6: A read miss on a modified line behaves as follows:
  - The old line is buffered.
  - A fill (mc_kind 0) of four beats is taken and written into the line.
  - The response, carrying the requested new word, comes before any write-back beat.
  - A write-back (mc_kind 1) of the four old words follows.
  - The line ends valid, and req_ready stays 0 until the write-back is complete.
- R7: A copyback write miss on a modified line fills the new line with the store data merged into the addressed word. It then writes back the four old words and leaves the line modified.
- R8: A miss on an invalid or valid line performs only the fill, with no write-back. A read then leaves the line valid, and a copyback write (merged) leaves it modified.
- R9: Invalidate (req_op 2) moves the line to invalid with no memory traffic. Modified data is discarded.
- R10: Push-and-invalidate (req_op 3) and push-and-keep (req_op 4) on a modified line write back all four words with mc_kind 1. The line then ends invalid or valid respectively, and the response comes only after the last beat.
- R11: Either push command on a line that is not modified causes no memory traffic. Push-and-invalidate leaves it invalid; push-and-keep leaves the state unchanged.
- R12: A request is accepted only while req_ready is 1, which is only when the controller is idle. A hit flag given while the line is invalid is ignored, and the access is treated as a miss.
- R13: Once mc_valid or wd_valid is raised, it stays high, with kind, word index and data unchanged, until the matching ready is seen. Burst beats move words 0 to 3 in ascending order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request offered |
| req_ready | output | 1 | Controller idle, request taken this cycle if valid |
| req_op | input | 3 | 0 read, 1 write, 2 invalidate, 3 push-invalidate, 4 push-keep |
| req_hit | input | 1 | Tag match from outside |
| req_wt | input | 1 | Write-through mode for this write (0 = copyback) |
| req_idx | input | 2 | Word index within the line |
| req_wdata | input | 32 | Store data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read data, meaningful with rsp_valid on a read |
| line_state | output | 2 | Current line state |
| mc_valid | output | 1 | Memory command offered |
| mc_ready | input | 1 | Memory command taken |
| mc_kind | output | 2 | 0 fill burst, 1 write-back burst, 2 single word |
| mc_word | output | 2 | Word index for a single-word write, 0 for bursts |
| fd_valid | input | 1 | Fill beat offered |
| fd_ready | output | 1 | Controller takes fill beats |
| fd_data | input | 32 | Fill beat data |
| wd_valid | output | 1 | Write beat offered |
| wd_ready | input | 1 | Memory takes write beat |
| wd_data | output | 32 | Write beat data |

## Verification
The hardest case to reach is a miss on a dirty line that has just been made dirty by a copyback store. Here the fill, the merged store, the early response and the delayed write-back of the victim all overlap while memory stalls mid-burst. The stimulus first dirties a known line with copyback write hits. It then issues the miss while the memory stub throttles the command, fill and write channels on different rotating patterns. A behavioural model predicts the fill, write-back order and response timing, and the bench reads the merged line back through later read hits.

// File: rtl/clc_pkg.sv
package clc_pkg;

  typedef enum logic [1:0] {
    LS_INVALID  = 2'd0,
    LS_VALID    = 2'd1,
    LS_MODIFIED = 2'd2
  } line_state_e;

  typedef enum logic [2:0] {
    OP_READ      = 3'd0,
    OP_WRITE     = 3'd1,
    OP_INVAL     = 3'd2,
    OP_PUSH_INV  = 3'd3,
    OP_PUSH_KEEP = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    MK_FILL  = 2'd0,
    MK_WBACK = 2'd1,
    MK_WORD  = 2'd2
  } mem_kind_e;

  typedef enum logic [2:0] {
    CS_IDLE,
    CS_FILL_CMD,
    CS_FILL_DATA,
    CS_WB_CMD,
    CS_WB_DATA,
    CS_WT_CMD,
    CS_WT_DATA
  } ctl_state_e;

endpackage

// File: rtl/clc_line_store.sv
module clc_line_store #(
  parameter int DW    = 32,
  parameter int WORDS = 4,
  localparam int IW   = $clog2(WORDS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [IW-1:0]       wr_idx,
  input  logic [DW-1:0]       wr_data,
  input  logic [IW-1:0]       rd_idx,
  output logic [DW-1:0]       rd_data,
  output logic [WORDS*DW-1:0] line_flat
);

  logic [DW-1:0] word_q [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)                                   word_q[w] <= '0;
      else if (wr_en && (wr_idx == IW'(w)))         word_q[w] <= wr_data;
    end
    assign line_flat[w*DW +: DW] = word_q[w];
  end

  assign rd_data = word_q[rd_idx];

endmodule

// File: rtl/clc_push_buf.sv
module clc_push_buf #(
  parameter int DW    = 32,
  parameter int WORDS = 4,
  localparam int IW   = $clog2(WORDS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [WORDS*DW-1:0] line_in,
  input  logic [IW-1:0]       rd_idx,
  output logic [DW-1:0]       rd_data
);

  logic [DW-1:0] slot_q [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)    slot_q[w] <= '0;
      else if (load) slot_q[w] <= line_in[w*DW +: DW];
    end
  end

  assign rd_data = slot_q[rd_idx];

endmodule

// File: rtl/clc_line_ctrl.sv
module clc_line_ctrl
  import clc_pkg::*;
#(
  parameter int DW    = 32,
  parameter int WORDS = 4,
  localparam int IW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [2:0]    req_op,
  input  logic          req_hit,
  input  logic          req_wt,
  input  logic [IW-1:0] req_idx,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [1:0]    line_state,
  output logic          mc_valid,
  input  logic          mc_ready,
  output logic [1:0]    mc_kind,
  output logic [IW-1:0] mc_word,
  input  logic          fd_valid,
  output logic          fd_ready,
  input  logic [DW-1:0] fd_data,
  output logic          wd_valid,
  input  logic          wd_ready,
  output logic [DW-1:0] wd_data
);

  localparam logic [IW-1:0] LAST_BEAT = IW'(WORDS - 1);

  ctl_state_e  state_q;
  line_state_e lstate_q;
  op_e         op_q;
  logic [IW-1:0] idx_q, beat_q;
  logic [DW-1:0] wdata_q;
  logic          hit_q, pb_full_q;
  logic          rsp_valid_q;
  logic [DW-1:0] rsp_rdata_q;

  op_e  req_op_e;
  logic accept, eff_hit, line_dirty;

  assign req_op_e   = op_e'(req_op);
  assign req_ready  = (state_q == CS_IDLE);
  assign accept     = req_valid && req_ready;
  assign eff_hit    = req_hit && (lstate_q != LS_INVALID);
  assign line_dirty = (lstate_q == LS_MODIFIED);

  // line storage write port
  logic          st_we;
  logic [IW-1:0] st_idx;
  logic [DW-1:0] st_wd;
  logic [DW-1:0] st_rd;
  logic [WORDS*DW-1:0] st_line;

  always_comb begin
    st_we  = 1'b0;
    st_idx = req_idx;
    st_wd  = req_wdata;
    unique case (state_q)
      CS_IDLE: begin
        st_we = accept && (req_op_e == OP_WRITE) && !req_wt && eff_hit;
      end
      CS_FILL_DATA: begin
        st_we  = fd_valid;
        st_idx = beat_q;
        st_wd  = ((op_q == OP_WRITE) && (beat_q == idx_q)) ? wdata_q : fd_data;
      end
      CS_WT_DATA: begin
        st_we  = wd_ready && hit_q;
        st_idx = idx_q;
        st_wd  = wdata_q;
      end
      default: ;
    endcase
  end

  clc_line_store #(.DW(DW), .WORDS(WORDS)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (st_we),
    .wr_idx    (st_idx),
    .wr_data   (st_wd),
    .rd_idx    (req_idx),
    .rd_data   (st_rd),
    .line_flat (st_line)
  );

  // victim buffer, captured when a request finds the line dirty
  logic          pb_load;
  logic [DW-1:0] pb_rd;

  assign pb_load = accept && line_dirty &&
                   (((req_op_e == OP_READ) && !eff_hit) ||
                    ((req_op_e == OP_WRITE) && !req_wt && !eff_hit) ||
                    (req_op_e == OP_PUSH_INV) || (req_op_e == OP_PUSH_KEEP));

  clc_push_buf #(.DW(DW), .WORDS(WORDS)) u_pbuf (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (pb_load),
    .line_in (st_line),
    .rd_idx  (beat_q),
    .rd_data (pb_rd)
  );

  // memory side outputs decoded from the sequencer state
  always_comb begin
    mc_valid = 1'b0;
    mc_kind  = MK_FILL;
    mc_word  = '0;
    unique case (state_q)
      CS_FILL_CMD: mc_valid = 1'b1;
      CS_WB_CMD:   begin mc_valid = 1'b1; mc_kind = MK_WBACK; end
      CS_WT_CMD:   begin mc_valid = 1'b1; mc_kind = MK_WORD; mc_word = idx_q; end
      default: ;
    endcase
  end

  assign fd_ready   = (state_q == CS_FILL_DATA);
  assign wd_valid   = (state_q == CS_WB_DATA) || (state_q == CS_WT_DATA);
  assign wd_data    = (state_q == CS_WB_DATA) ? pb_rd : wdata_q;
  assign rsp_valid  = rsp_valid_q;
  assign rsp_rdata  = rsp_rdata_q;
  assign line_state = lstate_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= CS_IDLE;
      lstate_q    <= LS_INVALID;
      op_q        <= OP_READ;
      idx_q       <= '0;
      beat_q      <= '0;
      wdata_q     <= '0;
      hit_q       <= 1'b0;
      pb_full_q   <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      unique case (state_q)
        CS_IDLE: if (accept) begin
          op_q    <= req_op_e;
          idx_q   <= req_idx;
          wdata_q <= req_wdata;
          hit_q   <= eff_hit;
          beat_q  <= '0;
          case (req_op_e)
            OP_READ: begin
              if (eff_hit) begin
                rsp_valid_q <= 1'b1;
                rsp_rdata_q <= st_rd;
              end else begin
                pb_full_q <= line_dirty;
                state_q   <= CS_FILL_CMD;
              end
            end
            OP_WRITE: begin
              if (req_wt) begin
                state_q <= CS_WT_CMD;
              end else if (eff_hit) begin
                lstate_q    <= LS_MODIFIED;
                rsp_valid_q <= 1'b1;
              end else begin
                pb_full_q <= line_dirty;
                state_q   <= CS_FILL_CMD;
              end
            end
            OP_INVAL: begin
              lstate_q    <= LS_INVALID;
              rsp_valid_q <= 1'b1;
            end
            OP_PUSH_INV, OP_PUSH_KEEP: begin
              if (line_dirty) begin
                pb_full_q <= 1'b1;
                state_q   <= CS_WB_CMD;
              end else begin
                if (req_op_e == OP_PUSH_INV) lstate_q <= LS_INVALID;
                rsp_valid_q <= 1'b1;
              end
            end
            default: rsp_valid_q <= 1'b1;
          endcase
        end
        CS_FILL_CMD: if (mc_ready) state_q <= CS_FILL_DATA;
        CS_FILL_DATA: if (fd_valid) begin
          if ((op_q == OP_READ) && (beat_q == idx_q)) rsp_rdata_q <= fd_data;
          beat_q <= beat_q + IW'(1);
          if (beat_q == LAST_BEAT) begin
            lstate_q    <= (op_q == OP_WRITE) ? LS_MODIFIED : LS_VALID;
            rsp_valid_q <= 1'b1;
            beat_q      <= '0;
            state_q     <= pb_full_q ? CS_WB_CMD : CS_IDLE;
          end
        end
        CS_WB_CMD: if (mc_ready) state_q <= CS_WB_DATA;
        CS_WB_DATA: if (wd_ready) begin
          beat_q <= beat_q + IW'(1);
          if (beat_q == LAST_BEAT) begin
            beat_q    <= '0;
            pb_full_q <= 1'b0;
            state_q   <= CS_IDLE;
            if (op_q == OP_PUSH_INV) begin
              lstate_q    <= LS_INVALID;
              rsp_valid_q <= 1'b1;
            end else if (op_q == OP_PUSH_KEEP) begin
              lstate_q    <= LS_VALID;
              rsp_valid_q <= 1'b1;
            end
          end
        end
        CS_WT_CMD: if (mc_ready) state_q <= CS_WT_DATA;
        CS_WT_DATA: if (wd_ready) begin
          if (hit_q) lstate_q <= LS_VALID;
          rsp_valid_q <= 1'b1;
          state_q     <= CS_IDLE;
        end
        default: state_q <= CS_IDLE;
      endcase
    end
  end

  AST_MC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_valid && !mc_ready) |=> (mc_valid && $stable(mc_kind) && $stable(mc_word)))
    else $error("command dropped under stall"); // R13

  AST_WD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_valid && !wd_ready) |=> (wd_valid && $stable(wd_data)))
    else $error("write beat changed under stall"); // R13

  AST_INV_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (req_op == 3'd2)) |=> ((line_state == 2'd0) && !mc_valid && req_ready))
    else $error("invalidate did not drop line quietly"); // R9

  AST_CLEAN_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && ((req_op == 3'd3) || (req_op == 3'd4)) && (line_state != 2'd2))
      |=> (!mc_valid && req_ready))
    else $error("push of clean line made traffic"); // R11

  AST_HIT_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (req_op == 3'd0) && req_hit && (line_state != 2'd0)) |=> (rsp_valid && req_ready))
    else $error("read hit not answered next cycle"); // R2

  AST_CB_HIT_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (req_op == 3'd1) && !req_wt && req_hit && (line_state != 2'd0))
      |=> (line_state == 2'd2))
    else $error("copyback write hit did not dirty line"); // R3

  AST_WT_MISS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (req_op == 3'd1) && req_wt && !(req_hit && (line_state != 2'd0)))
      |=> $stable(line_state))
    else $error("write-through miss changed state"); // R5

endmodule

// File: tb/clc_line_ctrl_bench.sv
module clc_line_ctrl_bench;

  logic clk = 1'b0;
  logic rst_n;
  always #10 clk = ~clk;

  logic        req_valid, req_ready, req_hit, req_wt;
  logic [2:0]  req_op;
  logic [1:0]  req_idx;
  logic [31:0] req_wdata;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [1:0]  line_state;
  logic        mc_valid, mc_ready;
  logic [1:0]  mc_kind, mc_word;
  logic        fd_valid, fd_ready;
  logic [31:0] fd_data;
  logic        wd_valid, wd_ready;
  logic [31:0] wd_data;

  clc_line_ctrl u_clc_line_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_hit(req_hit), .req_wt(req_wt), .req_idx(req_idx), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .line_state(line_state),
    .mc_valid(mc_valid), .mc_ready(mc_ready), .mc_kind(mc_kind), .mc_word(mc_word),
    .fd_valid(fd_valid), .fd_ready(fd_ready), .fd_data(fd_data),
    .wd_valid(wd_valid), .wd_ready(wd_ready), .wd_data(wd_data)
  );

  int vectors = 0;
  int fails   = 0;
  int cyc     = 0;

  // behavioural reference state
  logic [31:0] mline [4];
  int          mstate = 0;
  bit          in_flight = 0;

  logic [31:0] fill_q [4];
  int          fill_idx = 4;
  int          fill_seq = 0;
  int          cmd_log [$];
  logic [31:0] wr_log  [$];
  bit          rsp_seen;
  logic [31:0] rsp_data;
  int          wr_at_rsp;
  bit          ready_at_rsp;

  bit          prev_mc_stall = 0, prev_wd_stall = 0;
  logic [1:0]  prev_kind, prev_word;
  logic [31:0] prev_wd;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  // memory stub and per-clock comparison
  initial begin
    mc_ready = 0; wd_ready = 0; fd_valid = 0; fd_data = '0;
    forever begin
      @(negedge clk);
      cyc++;
      mc_ready = (cyc % 3) != 1;
      wd_ready = (cyc % 4) != 2;
      fd_valid = (fill_idx < 4) && ((cyc % 5) != 3);
      fd_data  = fd_valid ? fill_q[fill_idx] : 32'h0;
      #1;
      if (rst_n) begin
        if (prev_mc_stall) begin   // R13 hold under stall
          chk("R13", "mc held", {29'd0, mc_valid, mc_kind == prev_kind, mc_word == prev_word}, 32'h7);
        end
        if (prev_wd_stall) begin
          chk("R13", "wd valid held", {31'd0, wd_valid}, 32'd1);
          chk("R13", "wd data held", wd_data, prev_wd);
        end
        if (!in_flight) begin
          chk("R12", "idle ready", {31'd0, req_ready}, 32'd1);
          chk("R12", "idle state", {30'd0, line_state}, 32'(mstate));
        end
      end
      prev_mc_stall = rst_n && mc_valid && !mc_ready;
      prev_wd_stall = rst_n && wd_valid && !wd_ready;
      prev_kind = mc_kind; prev_word = mc_word; prev_wd = wd_data;
      if (mc_valid && mc_ready) cmd_log.push_back(int'(mc_kind) * 4 + int'(mc_word));
      if (wd_valid && wd_ready) wr_log.push_back(wd_data);
      if (fd_valid && fd_ready) fill_idx++;
      if (rsp_valid && !rsp_seen) begin
        rsp_seen     = 1;
        rsp_data     = rsp_rdata;
        wr_at_rsp    = wr_log.size();
        ready_at_rsp = req_ready;
      end
    end
  end

  task automatic do_op(input string tag, input int op, input bit hit, input bit wt,
                       input int idx, input logic [31:0] wd);
    int          exp_cmds [$];
    logic [31:0] exp_wr   [$];
    logic [31:0] old [4];
    logic [31:0] exp_rd;
    bit          is_read, wb_after_fill, wb_push, eff;
    int          guard;
    is_read = 0; wb_after_fill = 0; wb_push = 0; exp_rd = '0;
    eff = hit && (mstate != 0);
    fill_seq++;
    for (int i = 0; i < 4; i++) begin
      fill_q[i] = 32'hF000_0000 | 32'(fill_seq << 8) | 32'(i);
      old[i]    = mline[i];
    end
    case (op)
      0: begin
        is_read = 1;
        if (eff) exp_rd = mline[idx];
        else begin
          exp_cmds.push_back(0);
          if (mstate == 2) begin
            exp_cmds.push_back(4);
            for (int i = 0; i < 4; i++) exp_wr.push_back(old[i]);
            wb_after_fill = 1;
          end
          for (int i = 0; i < 4; i++) mline[i] = fill_q[i];
          exp_rd = fill_q[idx];
          mstate = 1;
        end
      end
      1: begin
        if (wt) begin
          exp_cmds.push_back(8 + idx);
          exp_wr.push_back(wd);
          if (eff) begin mline[idx] = wd; mstate = 1; end
        end else if (eff) begin
          mline[idx] = wd; mstate = 2;
        end else begin
          exp_cmds.push_back(0);
          if (mstate == 2) begin
            exp_cmds.push_back(4);
            for (int i = 0; i < 4; i++) exp_wr.push_back(old[i]);
            wb_after_fill = 1;
          end
          for (int i = 0; i < 4; i++) mline[i] = fill_q[i];
          mline[idx] = wd;
          mstate = 2;
        end
      end
      2: mstate = 0;
      default: begin
        if (mstate == 2) begin
          exp_cmds.push_back(4);
          for (int i = 0; i < 4; i++) exp_wr.push_back(old[i]);
          wb_push = 1;
          mstate = (op == 3) ? 0 : 1;
        end else if (op == 3) mstate = 0;
      end
    endcase
    fill_idx = (exp_cmds.size() > 0 && exp_cmds[0] == 0) ? 0 : 4;
    cmd_log.delete(); wr_log.delete(); rsp_seen = 0;
    in_flight = 1;
    @(negedge clk);
    req_valid = 1; req_op = 3'(op); req_hit = hit; req_wt = wt;
    req_idx = 2'(idx); req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    guard = 0;
    forever begin
      #2;
      if (rsp_seen && req_ready) break;
      guard++;
      if (guard > 200) break;
      @(negedge clk);
    end
    chk(tag, "completed", {31'd0, rsp_seen}, 32'd1);
    chk(tag, "cmd count", 32'(cmd_log.size()), 32'(exp_cmds.size()));
    for (int i = 0; i < exp_cmds.size() && i < cmd_log.size(); i++)
      chk(tag, "cmd kind/word", 32'(cmd_log[i]), 32'(exp_cmds[i]));
    chk(tag, "write beats", 32'(wr_log.size()), 32'(exp_wr.size()));
    for (int i = 0; i < exp_wr.size() && i < wr_log.size(); i++)
      chk(tag, "write beat data", wr_log[i], exp_wr[i]);   // ascending order, R13
    if (is_read) chk(tag, "read data", rsp_data, exp_rd);
    if (wb_after_fill) begin
      chk(tag, "rsp before write-back", 32'(wr_at_rsp), 32'd0);
      chk(tag, "busy at early rsp", {31'd0, ready_at_rsp}, 32'd0);
    end
    if (wb_push) chk(tag, "rsp after write-back", 32'(wr_at_rsp), 32'd4);
    chk(tag, "final state", {30'd0, line_state}, 32'(mstate));
    in_flight = 0;
  endtask

  initial begin
    for (int i = 0; i < 4; i++) mline[i] = '0;
    rst_n = 0; req_valid = 0; req_op = 0; req_hit = 0; req_wt = 0;
    req_idx = 0; req_wdata = 0;
    repeat (3) @(negedge clk);
    #2;
    chk("R1", "reset state", {30'd0, line_state}, 32'd0);
    chk("R1", "reset quiet", {29'd0, mc_valid, wd_valid, rsp_valid}, 32'd0);
    rst_n = 1;
    @(negedge clk); #2;
    chk("R1", "ready after reset", {31'd0, req_ready}, 32'd1);

    do_op("R12", 0, 1, 0, 2, 32'h0);           // hit flag on invalid line -> fill
    do_op("R8",  0, 0, 0, 1, 32'h0);           // read miss on valid line
    do_op("R2",  0, 1, 0, 3, 32'h0);           // read hit
    do_op("R3",  1, 1, 0, 1, 32'hAAAA_0001);   // copyback write hit -> M
    do_op("R2",  0, 1, 0, 1, 32'h0);           // read hit on modified
    do_op("R5",  1, 0, 1, 2, 32'hBBBB_0002);   // write-through miss on M
    do_op("R5",  0, 1, 0, 2, 32'h0);           // cache unchanged
    do_op("R4",  1, 1, 1, 3, 32'hCCCC_0003);   // write-through hit -> V
    do_op("R4",  0, 1, 0, 3, 32'h0);
    do_op("R3",  1, 1, 0, 0, 32'hDDDD_0004);
    do_op("R6",  0, 0, 0, 2, 32'h0);           // read miss on M
    do_op("R3",  1, 1, 0, 3, 32'hEEEE_0005);
    do_op("R7",  1, 0, 0, 1, 32'h1234_5678);   // copyback write miss on M
    do_op("R7",  0, 1, 0, 1, 32'h0);
    do_op("R7",  0, 1, 0, 0, 32'h0);
    do_op("R10", 4, 0, 0, 0, 32'h0);           // push-keep on M
    do_op("R11", 4, 0, 0, 0, 32'h0);           // push-keep on V
    do_op("R3",  1, 1, 0, 2, 32'h5555_0006);
    do_op("R10", 3, 0, 0, 0, 32'h0);           // push-invalidate on M
    do_op("R11", 3, 0, 0, 0, 32'h0);           // push-invalidate on I
    do_op("R8",  1, 0, 0, 2, 32'h7777_0007);   // copyback write miss on I
    do_op("R8",  0, 1, 0, 2, 32'h0);
    do_op("R9",  2, 0, 0, 0, 32'h0);           // invalidate modified line
    do_op("R5",  1, 1, 1, 1, 32'h9999_0008);   // write-through with hit flag on I
    do_op("R11", 4, 0, 0, 0, 32'h0);
    do_op("R12", 0, 1, 0, 0, 32'h0);

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected completion");
    summary();
    $finish;
  end

endmodule